// File: doc/BRIEF.md
# Power-Pulsing Enable Sequencer

This block turns a single acquisition level into a set of timed control phases for a chip that is powered up only while acquisition runs. One input level, `acq_i`, fans out into a bias enable, an input-stage full-current mode, a short stabilizer kick pulse, a global channel mask and a receiver enable. The receiver enable also gates the internal system clock. Each staged output follows the acquisition level after its own programmable delay. The delay applies to the rising edge and to the falling edge alike.

All counters run from the free-running reference clock `clk_i`. The receiver enable therefore keeps a programmable tail after acquisition ends, so work already under way can finish. The gated clock is formed as the inverted receiver enable ORed with the receiver's clock, so it stays high while the receiver is off. Channels stay masked until the receiver has had time to settle. If acquisition comes back before a pending power-down has taken effect, that power-down is cancelled.

Top module: `pwr_pulse_seq`

## Requirements
- R1: After reset, `rx_en_o`, `bias_en_o`, `in_full_o` and `kick_o` are 0, and `chan_mask_o` is 1.
- R2: `rx_en_o` becomes 1 on the first `clk_i` edge that samples `acq_i` high. It stays 1 while `acq_i` is high.
- R3: After the first edge that samples `acq_i` low, `rx_en_o` stays 1 for `tail_len_i` more edges and drops on the edge `tail_len_i` cycles later. A tail of 0 drops it on that first edge.
- R4: `sys_clk_o` equals `~rx_en_o | rx_clk_i`. It is therefore 1 whenever the receiver is disabled.
- R5: The stage outputs are the bias stage (`dly_i` index 0 drives `bias_en_o`), the input stage (index 1 drives `in_full_o`) and the channel stage (index 2). Each takes the new `acq_i` level on the edge D cycles after the edge that first samples the change, where D is its delay field. D = 0 switches on that same edge.
- R6: The kick stage (`dly_i` index 3, delay Dk) raises `kick_o` on the edge Dk cycles after the rising acquisition edge. The pulse lasts exactly `kick_len_i` cycles. A length of 0 produces no pulse.
- R7: `chan_mask_o` is 0 only while the channel stage is on, `rx_en_o` is 1, and at least SETTLE_CYC (default 2) edges have passed since `rx_en_o` rose. Otherwise it is 1.
- R8: If `acq_i` returns high before a scheduled turn-off takes effect, `rx_en_o` and the stage outputs that were on remain on without a glitch.
- R9: A stage delay at the field maximum (255 for 8-bit fields) is honoured exactly, on both edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_i | input | 1 | Acquisition level, synchronous to clk_i |
| rx_clk_i | input | 1 | Clock from the receiver output |
| dly_i | input | 4 x DLY_W | Per-stage delays: 0 bias, 1 input mode, 2 channel, 3 kick |
| kick_len_i | input | DLY_W | Kick pulse length in cycles |
| tail_len_i | input | DLY_W | Extra receiver-enable cycles after acquisition ends |
| rx_en_o | output | 1 | Receiver power and clock enable |
| sys_clk_o | output | 1 | Gated system clock |
| bias_en_o | output | 1 | Global bias enable |
| in_full_o | output | 1 | Input stage at nominal current |
| kick_o | output | 1 | Stabilizer kick pulse |
| chan_mask_o | output | 1 | Global channel mask, 1 = masked |

## Verification
The main sequence is run with four delay sets. Together they cover:
- zero delays,
- stage delays ordered differently from one another,
- a channel delay shorter than the settle window,
- tails of 0, 2, 4 and 8.

Each set exposes a different case: an off-by-one on the rising or falling edge, stages whose delay fields are swapped, the tail being measured from the wrong edge, and the mask ignoring the settle rule. Directed cases cover:
- a short drop in acquisition that must not power anything down,
- a zero-length kick,
- the 255-cycle delay limit,
- the receiver clock passing through to `sys_clk_o`.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int N_STG     = 4;
  localparam int STG_BIAS  = 0;
  localparam int STG_INM   = 1;
  localparam int STG_CHAN  = 2;
  localparam int STG_KICK  = 3;
endpackage

// File: rtl/pps_stage.sv
module pps_stage #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acq_i,
  input  logic             acq_q_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             lvl_o,
  output logic             rise_o
);
  logic             pend_q, tgt_q, lvl_q, lvl_d;
  logic [DLY_W-1:0] cnt_q;
  logic             edge_w;

  assign edge_w = acq_i ^ acq_q_i;

  always_comb begin
    lvl_d = lvl_q;
    if (edge_w) begin
      if (dly_i == '0) lvl_d = acq_i;
    end else if (pend_q && cnt_q == DLY_W'(1)) begin
      lvl_d = tgt_q;
    end
  end

  // a new edge restarts the count with the new target (cancels pending)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      if (edge_w) begin
        tgt_q  <= acq_i;
        cnt_q  <= dly_i;
        pend_q <= (dly_i != '0);
      end else if (pend_q) begin
        if (cnt_q == DLY_W'(1)) pend_q <= 1'b0;
        else                    cnt_q  <= cnt_q - DLY_W'(1);
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_d & ~lvl_q;
endmodule

// File: rtl/pps_kick.sv
module pps_kick #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [DLY_W-1:0] len_i,
  output logic             kick_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fire_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - DLY_W'(1);
  end

  assign kick_o = (cnt_q != '0);
endmodule

// File: rtl/pps_rxen.sv
module pps_rxen #(
  parameter int DLY_W      = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acq_i,
  input  logic [DLY_W-1:0] tail_i,
  output logic             rx_en_o,
  output logic             settled_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic             en_q;
  logic [DLY_W-1:0] tcnt_q;
  logic [SW-1:0]    scnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      tcnt_q <= '0;
    end else if (acq_i) begin
      en_q   <= 1'b1;
      tcnt_q <= tail_i;
    end else if (en_q) begin
      if (tcnt_q == '0) en_q   <= 1'b0;
      else              tcnt_q <= tcnt_q - DLY_W'(1);
    end
  end

  // receiver clock undefined for the first cycles after enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         scnt_q <= '0;
    else if (!en_q)                      scnt_q <= '0;
    else if (scnt_q != SW'(SETTLE_CYC))  scnt_q <= scnt_q + SW'(1);
  end

  assign rx_en_o   = en_q;
  assign settled_o = (scnt_q == SW'(SETTLE_CYC));
endmodule

// File: rtl/pwr_pulse_seq.sv
module pwr_pulse_seq
  import pps_pkg::*;
#(
  parameter int DLY_W      = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acq_i,
  input  logic                        rx_clk_i,
  input  logic [N_STG-1:0][DLY_W-1:0] dly_i,
  input  logic [DLY_W-1:0]            kick_len_i,
  input  logic [DLY_W-1:0]            tail_len_i,
  output logic                        rx_en_o,
  output logic                        sys_clk_o,
  output logic                        bias_en_o,
  output logic                        in_full_o,
  output logic                        kick_o,
  output logic                        chan_mask_o
);
  logic             acq_q;
  logic [N_STG-1:0] lvl_w, rise_w;
  logic             settled_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acq_q <= 1'b0;
    else         acq_q <= acq_i;
  end

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    pps_stage #(.DLY_W(DLY_W)) u_stg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .acq_i   (acq_i),
      .acq_q_i (acq_q),
      .dly_i   (dly_i[g]),
      .lvl_o   (lvl_w[g]),
      .rise_o  (rise_w[g])
    );
  end

  pps_kick #(.DLY_W(DLY_W)) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (rise_w[STG_KICK]),
    .len_i  (kick_len_i),
    .kick_o (kick_o)
  );

  pps_rxen #(.DLY_W(DLY_W), .SETTLE_CYC(SETTLE_CYC)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acq_i     (acq_i),
    .tail_i    (tail_len_i),
    .rx_en_o   (rx_en_o),
    .settled_o (settled_w)
  );

  assign bias_en_o   = lvl_w[STG_BIAS];
  assign in_full_o   = lvl_w[STG_INM];
  assign chan_mask_o = ~(lvl_w[STG_CHAN] & settled_w & rx_en_o);
  assign sys_clk_o   = ~rx_en_o | rx_clk_i;
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic acq_i,
  input logic rx_clk_i,
  input logic rx_en_o,
  input logic sys_clk_o,
  input logic chan_mask_o
);
  AST_RX_FOLLOWS_ACQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_i |=> rx_en_o); // R2
  AST_RX_FALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_en_o) |-> !$past(acq_i)); // R3
  AST_CLK_HIGH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_o |-> sys_clk_o); // R4
  AST_MASK_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_o |-> chan_mask_o); // R7
  AST_MASK_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |=> chan_mask_o); // R7
endmodule

bind pwr_pulse_seq pps_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acq_i       (acq_i),
  .rx_clk_i    (rx_clk_i),
  .rx_en_o     (rx_en_o),
  .sys_clk_o   (sys_clk_o),
  .chan_mask_o (chan_mask_o)
);

// File: tb/sim_pwr_pulse_seq.sv
`timescale 1ns/1ps
module sim_pwr_pulse_seq;
  import pps_pkg::*;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, acq = 1'b0, rx_clk = 1'b0;
  logic [N_STG-1:0][DW-1:0] dly = '0;
  logic [DW-1:0] klen = '0, tail = '0;
  logic rx_en, sys_clk, bias, inm, kick, mask;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_pulse_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .rx_clk_i(rx_clk),
    .dly_i(dly), .kick_len_i(klen), .tail_len_i(tail),
    .rx_en_o(rx_en), .sys_clk_o(sys_clk), .bias_en_o(bias),
    .in_full_o(inm), .kick_o(kick), .chan_mask_o(mask)
  );

  // H, Dbias, Dinm, Dchan, Dkick, K, T
  localparam int VEC [4][7] = '{
    '{10,  0, 1,  0, 2, 3, 0},
    '{20,  5, 3,  7, 1, 1, 4},
    '{12,  2, 9,  1, 0, 5, 8},
    '{30, 11, 4, 20, 6, 2, 2}
  };

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b (rx,bias,inm,mask,kick,sclk)", req, act, exp);
    end
  endtask

  function automatic bit win(int n, int lo, int hi);
    return (n >= lo) && (n < hi);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic idle(int c);
    acq = 1'b0;
    repeat (c) @(negedge clk);
  endtask

  logic [5:0] outs;
  assign outs = {rx_en, bias, inm, mask, kick, sys_clk};

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", outs, 6'b000101);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs, 6'b000101);

    // table-driven sequence: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      int h, db, di, dc, dk, k, t;
      h = VEC[v][0]; db = VEC[v][1]; di = VEC[v][2]; dc = VEC[v][3];
      dk = VEC[v][4]; k = VEC[v][5]; t = VEC[v][6];
      dly[STG_BIAS] = DW'(db); dly[STG_INM] = DW'(di);
      dly[STG_CHAN] = DW'(dc); dly[STG_KICK] = DW'(dk);
      klen = DW'(k); tail = DW'(t); rx_clk = 1'b0;
      idle(5);
      acq = 1'b1;
      for (int n = 0; n < h + 40; n++) begin
        logic [5:0] e;
        @(negedge clk);
        e[5] = win(n, 0, h + t);                                   // R2 R3
        e[4] = win(n, db, h + db);                                 // R5
        e[3] = win(n, di, h + di);                                 // R5
        e[2] = !win(n, imax(dc, 2), imin(h + dc, h + t));          // R7
        e[1] = win(n, dk, dk + k);                                 // R6
        e[0] = !e[5];                                              // R4
        chk($sformatf("R2/R3/R4/R5/R6/R7 vec%0d n=%0d", v, n), outs, e);
        if (n == h - 1) acq = 1'b0;
      end
    end

    // R4: receiver clock passes through while enabled
    dly = '0; klen = '0; tail = '0;
    idle(5);
    acq = 1'b1;
    repeat (3) @(negedge clk);
    rx_clk = 1'b1; #1;
    chk("R4 pass high", {5'b0, sys_clk}, 6'd1);
    rx_clk = 1'b0; #1;
    chk("R4 pass low", {5'b0, sys_clk}, 6'd0);
    idle(5);
    chk("R4 forced high off", {5'b0, sys_clk}, 6'd1);

    // R8: abort of power-down
    dly[STG_BIAS] = 8'd3; dly[STG_INM] = 8'd3; tail = 8'd10; klen = 8'd1;
    idle(20);
    acq = 1'b1;
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      if (n >= 5) chk($sformatf("R8 abort n=%0d", n), {rx_en, bias, inm, 3'b0}, 6'b111000);
      if (n == 9)  acq = 1'b0;
      if (n == 11) acq = 1'b1;
    end
    idle(30);

    // R6: zero-length kick
    dly = '0; klen = '0; tail = '0;
    acq = 1'b1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk($sformatf("R6 zero kick n=%0d", n), {5'b0, kick}, 6'd0);
    end
    idle(10);

    // R9: maximum delay on both edges
    dly = '0; dly[STG_BIAS] = 8'd255;
    acq = 1'b1;
    for (int n = 0; n < 300 + 260; n++) begin
      @(negedge clk);
      if (n == 254) chk("R9 rise not early", {5'b0, bias}, 6'd0);
      if (n == 255) chk("R9 rise at 255", {5'b0, bias}, 6'd1);
      if (n == 554) chk("R9 fall not early", {5'b0, bias}, 6'd1);
      if (n == 555) chk("R9 fall at 255", {5'b0, bias}, 6'd0);
      if (n == 299) acq = 1'b0;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule